// File: doc/BRIEF.md
# ATA Task-File Register Front End

This block is the device-side register front end of a parallel ATA-style disk interface in programmed-I/O operation. The host's strobes arrive asynchronously. They are brought into the core clock through short flop chains, and each access takes effect when its strobe ends. Two active-low selects and a 3-bit address pick one of eight task-file locations or the control-block location. Location 0 of the task file is the 16-bit data port. All other task-file locations carry one byte on the low lane. The control-block location is the alternate status on reads and the device control byte on writes.

A backend sits behind a small internal port. It supplies the status and error bytes and the next read data word, and it raises interrupts. It receives command bytes and written data words as one-cycle pulses. The block also produces the interrupt request, the active-low word-transfer indicator and the master/slave role read from a strap pin. Command execution, media access and DMA are handled elsewhere.

Host signals (selects, address, write data) must stay stable from before a strobe falls until at least four core cycles after it rises.

Top module: `ata_taskfile_fe`

## Requirements
- R1: After the core reset `rst` or a host reset (`hrst_n` low), the following hold. `intrq` is 0, `rdata_oe` is 0 and `word_n` is 1. The sector count (address 2) and LBA low (address 3) read 8'h01. Addresses 4, 5 and 6 read 8'h00. Interrupt masking is off and soft reset is off.
- R2: With `cs0_n`=0 and `cs1_n`=1, a write to address 2, 3, 4, 5 or 6 stores `wdata[7:0]`, and a later read returns that byte in `rdata[7:0]` with `rdata[15:8]`=0. A read of address 1 returns `be_error`.
- R3: `word_n` is 0 exactly when `cs0_n`=0, `cs1_n`=1 and `addr`=0, one cycle after those inputs settle, whether or not a strobe is active.
- R4: A write to the data port (`cs0_n`=0, `addr`=0) gives exactly one `be_wr_valid` pulse with all 16 bits of `wdata` on `be_wr_word`. A read of the data port returns all 16 bits of `be_rd_word` and gives one `be_rd_pop` pulse when the read strobe ends.
- R5: A write to address 7 under `cs0_n` gives exactly one `cmd_valid` pulse with `wdata[7:0]` on `cmd_code`. A read of address 7 returns the status byte, which is `be_status` with bit 7 (busy) forced to 1 while soft reset is set.
- R6: A write takes effect only after the rising (trailing) edge of `wr_n`. Nothing is issued while `wr_n` is held low.
- R7: `be_set_irq` sets a pending interrupt. `intrq` is high while an interrupt is pending and device-control bit 1 (mask) is 0. A status read (address 7 under `cs0_n`) clears the pending interrupt. An alternate status read (`cs1_n`=0, `addr`=6) returns the same byte without clearing it.
- R8: While device-control bit 2 (soft reset) is 1, the following hold. Task-file registers hold their R1 defaults. Status bit 7 reads 1. Task-file writes, commands and data writes are ignored, and interrupts are cleared and not raised. Writing device control with bit 2 = 0 ends this state.
- R9: When both `cs0_n` and `cs1_n` are low, no access happens: `rdata_oe` stays 0 and writes change nothing.
- R10: `is_master` is 1 when `strap_n` is low (grounded) and 0 when it is high (open, pulled up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high core reset |
| hrst_n | input | 1 | Host hardware reset, active low, asynchronous |
| strap_n | input | 1 | Master/slave strap, low means master |
| cs0_n | input | 1 | Task-file select, active low |
| cs1_n | input | 1 | Control-block select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data to host |
| rdata_oe | output | 1 | Read data drive enable |
| word_n | output | 1 | Word-transfer indicator, active low |
| intrq | output | 1 | Interrupt request, active high |
| is_master | output | 1 | Device role from the strap |
| be_status | input | 8 | Status byte from backend |
| be_error | input | 8 | Error byte from backend |
| be_set_irq | input | 1 | Backend interrupt raise pulse |
| be_rd_word | input | 16 | Next data word for host reads |
| be_rd_pop | output | 1 | Pulse: host consumed a data word |
| be_wr_word | output | 16 | Data word written by host |
| be_wr_valid | output | 1 | Pulse: `be_wr_word` is valid |
| cmd_code | output | 8 | Command byte written by host |
| cmd_valid | output | 1 | Pulse: `cmd_code` is valid |

## Verification
A wrong strobe-synchronizer state would show at the ports as a missing pulse or a doubled pulse on `cmd_valid` or `be_wr_valid`. It would show two cycles after the trailing edge, or, for a premature edge, while the strobe is still low. A corrupted pending-interrupt or mask state would show on `intrq` within one cycle of the causing event. Soft-reset state errors would show on the next status or register read, as a wrong busy bit or a non-default count byte. Decode errors would show on `word_n` one cycle after the address settles, or as a wrong `rdata_oe` during a select conflict.

// File: rtl/ata_fe_pkg.sv
package ata_fe_pkg;
  typedef enum logic [2:0] {
    TF_DATA   = 3'd0,
    TF_ERRFT  = 3'd1,
    TF_COUNT  = 3'd2,
    TF_LBA0   = 3'd3,
    TF_LBA1   = 3'd4,
    TF_LBA2   = 3'd5,
    TF_DEVSEL = 3'd6,
    TF_STCMD  = 3'd7
  } tf_addr_e;

  localparam logic [2:0] CTL_ADDR  = 3'd6;
  localparam int         CTL_NIEN  = 1;
  localparam int         CTL_SRST  = 2;
  localparam int         STAT_BUSY = 7;
  localparam int         TF_DEPTH  = 8;

  function automatic logic [7:0] tf_default(input logic [2:0] idx);
    return (idx == TF_COUNT || idx == TF_LBA0) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/ata_fe_sync.sv
module ata_fe_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= INIT;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= INIT;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= INIT;
    else     prev <= chain[STAGES-1];
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/ata_fe_taskfile.sv
module ata_fe_taskfile
  import ata_fe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [2:0]        rd_idx,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] regs [TF_DEPTH];

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      for (int i = 0; i < TF_DEPTH; i++)
        regs[i] <= BYTE_W'(tf_default(3'(i)));
    end else if (wr_en) begin
      regs[wr_idx] <= wr_byte;
    end
  end

  assign rd_byte = regs[rd_idx];
endmodule

// File: rtl/ata_fe_ctrl.sv
module ata_fe_ctrl
  import ata_fe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_byte,
  input  logic              set_irq,
  input  logic              clr_irq,
  output logic              nien,
  output logic              srst,
  output logic              intrq
);
  logic pend_q, pend_d, nien_d, srst_d;

  always_comb begin
    nien_d = ctl_wr ? ctl_byte[CTL_NIEN] : nien;
    srst_d = ctl_wr ? ctl_byte[CTL_SRST] : srst;
    pend_d = pend_q;
    if (clr_irq) pend_d = 1'b0;
    if (set_irq) pend_d = 1'b1;
    if (srst_d)  pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nien   <= 1'b0;
      srst   <= 1'b0;
      pend_q <= 1'b0;
      intrq  <= 1'b0;
    end else begin
      nien   <= nien_d;
      srst   <= srst_d;
      pend_q <= pend_d;
      intrq  <= pend_d & ~nien_d;
    end
  end
endmodule

// File: rtl/ata_taskfile_fe.sv
module ata_taskfile_fe
  import ata_fe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hrst_n,
  input  logic              strap_n,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic [2:0]        addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              word_n,
  output logic              intrq,
  output logic              is_master,
  input  logic [7:0]        be_status,
  input  logic [7:0]        be_error,
  input  logic              be_set_irq,
  input  logic [DATA_W-1:0] be_rd_word,
  output logic              be_rd_pop,
  output logic [DATA_W-1:0] be_wr_word,
  output logic              be_wr_valid,
  output logic [7:0]        cmd_code,
  output logic              cmd_valid
);
  localparam int BYTE_W = DATA_W / 2;

  logic hrst_q, hrst_rise_unused;
  logic core_rst;
  logic rd_q, rd_rise, wr_q, wr_rise;

  ata_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_hrst_sync (
    .clk(clk), .rst(rst), .din(hrst_n), .q(hrst_q), .rise(hrst_rise_unused));

  assign core_rst = rst | ~hrst_q;

  ata_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rd_sync (
    .clk(clk), .rst(core_rst), .din(rd_n), .q(rd_q), .rise(rd_rise));

  ata_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_wr_sync (
    .clk(clk), .rst(core_rst), .din(wr_n), .q(wr_q), .rise(wr_rise));

  // address decode
  logic sel_tf, sel_cb, sel_ctl, is_data, is_stcmd, is_plain;
  assign sel_tf   = ~cs0_n & cs1_n;
  assign sel_cb   = cs0_n & ~cs1_n;
  assign sel_ctl  = sel_cb & (addr == CTL_ADDR);
  assign is_data  = sel_tf & (addr == TF_DATA);
  assign is_stcmd = sel_tf & (addr == TF_STCMD);
  assign is_plain = sel_tf & (addr >= TF_COUNT) & (addr <= TF_DEVSEL);

  logic nien, srst;
  logic tf_wr, ctl_wr, clr_irq;
  logic [BYTE_W-1:0] tf_rd_byte;
  logic [7:0] status_byte;

  assign tf_wr   = wr_rise & is_plain & ~srst;
  assign ctl_wr  = wr_rise & sel_ctl;
  assign clr_irq = rd_rise & is_stcmd;

  ata_fe_taskfile #(.BYTE_W(BYTE_W)) u_tf (
    .clk(clk), .rst(core_rst), .srst(srst), .wr_en(tf_wr), .wr_idx(addr),
    .wr_byte(wdata[BYTE_W-1:0]), .rd_idx(addr), .rd_byte(tf_rd_byte));

  ata_fe_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(core_rst), .ctl_wr(ctl_wr), .ctl_byte(wdata[BYTE_W-1:0]),
    .set_irq(be_set_irq), .clr_irq(clr_irq), .nien(nien), .srst(srst),
    .intrq(intrq));

  always_comb begin
    status_byte            = be_status;
    status_byte[STAT_BUSY] = be_status[STAT_BUSY] | srst;
  end

  logic [DATA_W-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (is_data)                            rdata_d = be_rd_word;
    else if (sel_tf && addr == TF_ERRFT)    rdata_d = DATA_W'(be_error);
    else if (is_stcmd || sel_ctl)           rdata_d = DATA_W'(status_byte);
    else if (is_plain)                      rdata_d = DATA_W'(tf_rd_byte);
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      rdata       <= '0;
      rdata_oe    <= 1'b0;
      word_n      <= 1'b1;
      is_master   <= 1'b0;
      be_rd_pop   <= 1'b0;
      be_wr_word  <= '0;
      be_wr_valid <= 1'b0;
      cmd_code    <= '0;
      cmd_valid   <= 1'b0;
    end else begin
      rdata       <= rdata_d;
      rdata_oe    <= ~rd_q & (sel_tf | sel_cb);
      word_n      <= ~is_data;
      is_master   <= ~strap_n;
      be_rd_pop   <= rd_rise & is_data;
      be_wr_valid <= wr_rise & is_data & ~srst;
      cmd_valid   <= wr_rise & is_stcmd & ~srst;
      if (wr_rise && is_data && !srst)  be_wr_word <= wdata;
      if (wr_rise && is_stcmd && !srst) cmd_code   <= wdata[7:0];
    end
  end
endmodule

// File: rtl/ata_fe_chk.sv
module ata_fe_chk (
  input logic       clk,
  input logic       core_rst,
  input logic       cs0_n,
  input logic       cs1_n,
  input logic [2:0] addr,
  input logic       rdata_oe,
  input logic       word_n,
  input logic       intrq,
  input logic       nien,
  input logic       srst,
  input logic       be_set_irq,
  input logic       cmd_valid,
  input logic       be_wr_valid
);
  // R9: conflicting selects never enable read data
  a_r9_no_oe_on_conflict: assert property (@(posedge clk) disable iff (core_rst)
    (!cs0_n && !cs1_n) |=> !rdata_oe);

  // R3: word indicator only follows a data-port decode
  a_r3_word_only_data: assert property (@(posedge clk) disable iff (core_rst)
    !word_n |-> $past(!cs0_n && cs1_n && addr == 3'd0));

  // R5: one command pulse per strobe
  a_r5_cmd_single: assert property (@(posedge clk) disable iff (core_rst)
    cmd_valid |=> !cmd_valid);

  // R4: one data-word pulse per strobe
  a_r4_wr_single: assert property (@(posedge clk) disable iff (core_rst)
    be_wr_valid |=> !be_wr_valid);

  // R7: masked interrupt stays low
  a_r7_mask_holds: assert property (@(posedge clk) disable iff (core_rst)
    nien |-> !intrq);

  // R7: interrupt rises only on a backend raise or an unmask
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (core_rst)
    $rose(intrq) |-> ($past(be_set_irq) || $fell(nien)));

  // R8: soft reset keeps interrupt low and blocks commands
  a_r8_srst_no_irq: assert property (@(posedge clk) disable iff (core_rst)
    srst |-> !intrq);
  a_r8_srst_no_cmd: assert property (@(posedge clk) disable iff (core_rst)
    srst |=> !cmd_valid);
endmodule

bind ata_taskfile_fe ata_fe_chk u_chk (
  .clk(clk), .core_rst(core_rst), .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr),
  .rdata_oe(rdata_oe), .word_n(word_n), .intrq(intrq), .nien(nien),
  .srst(srst), .be_set_irq(be_set_irq), .cmd_valid(cmd_valid),
  .be_wr_valid(be_wr_valid));

// File: tb/ata_taskfile_fe_bench.sv
module ata_taskfile_fe_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hrst_n = 1'b1, strap_n = 1'b0;
  logic        cs0_n = 1'b1, cs1_n = 1'b1;
  logic [2:0]  addr = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdata_oe, word_n, intrq, is_master;
  logic [7:0]  be_status = 8'h50, be_error = 8'h04;
  logic        be_set_irq = 1'b0;
  logic [15:0] be_rd_word = 16'h1234;
  logic        be_rd_pop, be_wr_valid, cmd_valid;
  logic [15:0] be_wr_word;
  logic [7:0]  cmd_code;

  int vectors = 0, miscompares = 0;
  int cmd_cnt = 0, wrw_cnt = 0, pop_cnt = 0;
  logic [7:0]  last_cmd = '0;
  logic [15:0] last_wrw = '0;
  bit done = 0;

  always #4 clk = ~clk;

  ata_taskfile_fe u_ata_taskfile_fe (
    .clk(clk), .rst(rst), .hrst_n(hrst_n), .strap_n(strap_n), .cs0_n(cs0_n),
    .cs1_n(cs1_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .word_n(word_n), .intrq(intrq),
    .is_master(is_master), .be_status(be_status), .be_error(be_error),
    .be_set_irq(be_set_irq), .be_rd_word(be_rd_word), .be_rd_pop(be_rd_pop),
    .be_wr_word(be_wr_word), .be_wr_valid(be_wr_valid), .cmd_code(cmd_code),
    .cmd_valid(cmd_valid));

  always @(posedge clk) begin
    if (cmd_valid)   begin cmd_cnt <= cmd_cnt + 1; last_cmd <= cmd_code; end
    if (be_wr_valid) begin wrw_cnt <= wrw_cnt + 1; last_wrw <= be_wr_word; end
    if (be_rd_pop)   pop_cnt <= pop_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic c0, input logic c1, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; addr = a; wdata = d;
    cycles(1); wr_n = 1'b0;
    cycles(4); wr_n = 1'b1;
    cycles(6); cs0_n = 1'b1; cs1_n = 1'b1;
    cycles(1);
  endtask

  task automatic host_read(input logic c0, input logic c1, input logic [2:0] a,
                           output logic [15:0] d, output logic oe);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; addr = a;
    cycles(1); rd_n = 1'b0;
    cycles(4); d = rdata; oe = rdata_oe;
    rd_n = 1'b1;
    cycles(6); cs0_n = 1'b1; cs1_n = 1'b1;
    cycles(1);
  endtask

  task automatic t_reset;
    logic [15:0] d; logic oe;
    chk("R1 intrq after reset", 32'(intrq), 32'd0);
    chk("R1 rdata_oe after reset", 32'(rdata_oe), 32'd0);
    chk("R1 word_n after reset", 32'(word_n), 32'd1);
    host_read(1'b0, 1'b1, 3'd2, d, oe);
    chk("R1 count default", 32'(d), 32'h01);
    host_read(1'b0, 1'b1, 3'd3, d, oe);
    chk("R1 lba0 default", 32'(d), 32'h01);
    host_read(1'b0, 1'b1, 3'd5, d, oe);
    chk("R1 lba2 default", 32'(d), 32'h00);
    chk("R10 grounded strap is master", 32'(is_master), 32'd1);
  endtask

  task automatic t_regs;
    logic [15:0] d; logic oe;
    for (int i = 2; i <= 6; i++) host_write(1'b0, 1'b1, 3'(i), {8'hFF, 8'hA0 + 8'(i)});
    for (int i = 2; i <= 6; i++) begin
      host_read(1'b0, 1'b1, 3'(i), d, oe);
      chk("R2 register readback", 32'(d), 32'(8'hA0 + 8'(i)));
      chk("R2 read oe", 32'(oe), 32'd1);
    end
    host_read(1'b0, 1'b1, 3'd1, d, oe);
    chk("R2 error byte", 32'(d), 32'h04);
  endtask

  task automatic t_word;
    @(negedge clk); cs0_n = 1'b0; cs1_n = 1'b1; addr = 3'd0;
    cycles(2); chk("R3 word_n on data port", 32'(word_n), 32'd0);
    addr = 3'd3;
    cycles(2); chk("R3 word_n on byte reg", 32'(word_n), 32'd1);
    cs0_n = 1'b1; cs1_n = 1'b0; addr = 3'd0;
    cycles(2); chk("R3 word_n under cs1", 32'(word_n), 32'd1);
    cs1_n = 1'b1; cycles(2);
  endtask

  task automatic t_data;
    logic [15:0] d; logic oe; int w0, p0;
    w0 = wrw_cnt; p0 = pop_cnt;
    host_write(1'b0, 1'b1, 3'd0, 16'hBEEF);
    chk("R4 one data write pulse", 32'(wrw_cnt - w0), 32'd1);
    chk("R4 data write word", 32'(last_wrw), 32'hBEEF);
    be_rd_word = 16'hC3A5;
    host_read(1'b0, 1'b1, 3'd0, d, oe);
    chk("R4 data read word", 32'(d), 32'hC3A5);
    chk("R4 one pop pulse", 32'(pop_cnt - p0), 32'd1);
  endtask

  task automatic t_cmd;
    logic [15:0] d; logic oe; int c0;
    c0 = cmd_cnt;
    @(negedge clk); cs0_n = 1'b0; cs1_n = 1'b1; addr = 3'd7; wdata = 16'h00EC;
    cycles(1); wr_n = 1'b0;
    cycles(6);
    chk("R6 no command while strobe low", 32'(cmd_cnt - c0), 32'd0);
    wr_n = 1'b1;
    cycles(6); cs0_n = 1'b1; cycles(1);
    chk("R6 command after trailing edge", 32'(cmd_cnt - c0), 32'd1);
    chk("R5 command code", 32'(last_cmd), 32'hEC);
    host_read(1'b0, 1'b1, 3'd7, d, oe);
    chk("R5 status read", 32'(d), 32'h0050);
  endtask

  task automatic pulse_irq;
    @(negedge clk); be_set_irq = 1'b1;
    @(negedge clk); be_set_irq = 1'b0;
    cycles(2);
  endtask

  task automatic t_irq;
    logic [15:0] d; logic oe;
    pulse_irq();
    chk("R7 intrq raised", 32'(intrq), 32'd1);
    host_read(1'b1, 1'b0, 3'd6, d, oe);
    chk("R7 alt status value", 32'(d), 32'h0050);
    chk("R7 alt status keeps irq", 32'(intrq), 32'd1);
    host_read(1'b0, 1'b1, 3'd7, d, oe);
    chk("R7 status read clears irq", 32'(intrq), 32'd0);
    host_write(1'b1, 1'b0, 3'd6, 16'h0002);
    pulse_irq();
    chk("R7 masked irq low", 32'(intrq), 32'd0);
    host_write(1'b1, 1'b0, 3'd6, 16'h0000);
    chk("R7 unmask shows pending", 32'(intrq), 32'd1);
    host_read(1'b0, 1'b1, 3'd7, d, oe);
    chk("R7 cleared again", 32'(intrq), 32'd0);
  endtask

  task automatic t_srst;
    logic [15:0] d; logic oe; int c0;
    host_write(1'b0, 1'b1, 3'd2, 16'h0033);
    pulse_irq();
    host_write(1'b1, 1'b0, 3'd6, 16'h0004);
    chk("R8 irq cleared by soft reset", 32'(intrq), 32'd0);
    host_read(1'b0, 1'b1, 3'd2, d, oe);
    chk("R8 count defaulted", 32'(d), 32'h01);
    host_read(1'b0, 1'b1, 3'd7, d, oe);
    chk("R8 busy forced", 32'(d), 32'h00D0);
    c0 = cmd_cnt;
    host_write(1'b0, 1'b1, 3'd7, 16'h0020);
    chk("R8 command ignored", 32'(cmd_cnt - c0), 32'd0);
    host_write(1'b0, 1'b1, 3'd2, 16'h0077);
    host_read(1'b0, 1'b1, 3'd2, d, oe);
    chk("R8 write ignored", 32'(d), 32'h01);
    host_write(1'b1, 1'b0, 3'd6, 16'h0000);
    host_read(1'b0, 1'b1, 3'd7, d, oe);
    chk("R8 busy released", 32'(d), 32'h0050);
    host_write(1'b0, 1'b1, 3'd2, 16'h0044);
    host_read(1'b0, 1'b1, 3'd2, d, oe);
    chk("R8 writes resume", 32'(d), 32'h44);
  endtask

  task automatic t_conflict;
    logic [15:0] d; logic oe; int c0;
    c0 = cmd_cnt;
    host_write(1'b0, 1'b0, 3'd2, 16'h0099);
    host_write(1'b0, 1'b0, 3'd7, 16'h0011);
    chk("R9 no command on conflict", 32'(cmd_cnt - c0), 32'd0);
    host_read(1'b0, 1'b0, 3'd2, d, oe);
    chk("R9 no oe on conflict", 32'(oe), 32'd0);
    host_read(1'b0, 1'b1, 3'd2, d, oe);
    chk("R9 register unchanged", 32'(d), 32'h44);
  endtask

  task automatic t_hreset;
    logic [15:0] d; logic oe;
    pulse_irq();
    @(negedge clk); hrst_n = 1'b0;
    cycles(4); hrst_n = 1'b1;
    cycles(4);
    chk("R1 host reset clears irq", 32'(intrq), 32'd0);
    host_read(1'b0, 1'b1, 3'd2, d, oe);
    chk("R1 host reset count default", 32'(d), 32'h01);
  endtask

  task automatic t_strap;
    @(negedge clk); strap_n = 1'b1;
    cycles(2);
    chk("R10 open strap is slave", 32'(is_master), 32'd0);
    strap_n = 1'b0;
    cycles(2);
    chk("R10 grounded strap again master", 32'(is_master), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cycles(4);
    rst = 1'b0;
    cycles(4);
    t_reset();
    t_regs();
    t_word();
    t_data();
    t_cmd();
    t_irq();
    t_srst();
    t_conflict();
    t_hreset();
    t_strap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule